// File: doc/BRIEF.md
# DMA Request FIFO Bridge

This block moves 16-bit words written by a host into a small FIFO and hands them to a single DMA channel, which stores them into a word-addressed memory through a plain write port. The host side has three registers: a transfer length, a FIFO data port and a request control register. The DMA side keeps a channel descriptor: destination address, transfer count, a two-bit channel control field with an enable bit and an end bit, and a global DMA enable.

The FIFO is emptied only in bursts that are a multiple of four words, and only while the channel is armed and the global enable is on. Each drained word goes out one per clock. It advances the destination by two and decrements both the DMA transfer count and the host-side length. Either counter reaching zero ends its side of the transfer on its own. While a burst is pending or running, the host port stalls through a ready signal.

Top module: `dreq_fifo_bridge`

## Requirements
- R1: After reset the length, control bits, FIFO level, full flag, destination, transfer count, channel control and global enable are all zero, no memory write is issued and `host_ready` is high.
- R2: A host write with `host_sel`=0 loads the transfer length with bits 1:0 forced to zero.
- R3: A host write with `host_sel`=1 is ignored, leaving the FIFO level unchanged, unless the transfer-active bit (`host_sel`=2 data bit 2) is set.
- R4: A burst starts only when the FIFO level is a nonzero multiple of four, the channel control field equals binary 01 (bit 0 enable, bit 1 end) and the global enable is 1.
- R5: Each drained word is written on consecutive clocks to the current destination, in FIFO order, after which the destination rises by 2 and the transfer count and host length each fall by one.
- R6: When the transfer count reaches zero the burst stops early and bit 1 of the channel control field is set.
- R7: The full flag is set when the level reaches the FIFO depth (default 8), and the level and full flag are cleared at the end of every burst.
- R8: When a burst leaves the host length at zero, the transfer-active bit is cleared.
- R9: A control write (`host_sel`=2) sets transfer-active from data bit 2, DMA-enable from bit 1 and RV from bit 0, and leaves the full flag unchanged.
- R10: `host_ready` is low from the cycle a burst is triggered until it ends, and a host write held across that time takes effect afterwards.
- R11: `count_mismatch` is high exactly when the transfer count differs from the zero-extended host length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register: 0 length, 1 FIFO data, 2 control |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Host write accepted this cycle |
| cfg_wr | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Descriptor field: 0 destination, 1 count, 2 channel control, 3 global enable |
| cfg_wdata | input | 32 | Descriptor write data |
| host_len | output | 16 | Host-side remaining length |
| req_active | output | 1 | Transfer-active bit |
| req_dma_en | output | 1 | DMA-enable bit |
| req_rv | output | 1 | RV bit |
| fifo_full | output | 1 | FIFO full flag |
| fifo_level | output | 4 | Words held in the FIFO |
| dest_addr | output | 32 | Destination address |
| xfer_count | output | 24 | DMA transfer count |
| chan_ctrl | output | 2 | Channel control: bit 0 enable, bit 1 end |
| dma_global_en | output | 1 | Global DMA enable |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| count_mismatch | output | 1 | Transfer count differs from host length |

## Verification
The assertions assume the host keeps `host_wr`, `host_sel` and `host_wdata` steady until it sees `host_ready` high. They also assume descriptor writes are not issued while a burst runs, because the burst's own updates win and such writes would be lost. The stimulus drives every input on the falling edge, waits on `host_ready` before releasing a host write, and changes the descriptor only while the FIFO is idle, either before the enables that start a burst or after the burst has ended.

// File: rtl/dreq_fifo_bridge.sv
module dreq_fifo_bridge #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int AW    = 32,
  parameter int CW    = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_wr,
  input  logic [1:0]                 host_sel,
  input  logic [DW-1:0]              host_wdata,
  output logic                       host_ready,
  input  logic                       cfg_wr,
  input  logic [1:0]                 cfg_sel,
  input  logic [AW-1:0]              cfg_wdata,
  output logic [DW-1:0]              host_len,
  output logic                       req_active,
  output logic                       req_dma_en,
  output logic                       req_rv,
  output logic                       fifo_full,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  output logic [AW-1:0]              dest_addr,
  output logic [CW-1:0]              xfer_count,
  output logic [1:0]                 chan_ctrl,
  output logic                       dma_global_en,
  output logic                       mem_we,
  output logic [AW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_wdata,
  output logic                       count_mismatch
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] SEL_LEN  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] CFG_DEST = 2'd0;
  localparam logic [1:0] CFG_CNT  = 2'd1;
  localparam logic [1:0] CFG_CHAN = 2'd2;
  localparam logic [1:0] CFG_GLB  = 2'd3;

  logic [DW-1:0] fifo_mem [DEPTH];
  logic          draining;
  logic [IW-1:0] rd_idx;
  logic [LW-1:0] drain_n;

  logic          trigger, hacc, push, last;
  logic [DW-1:0] len_next;
  logic [CW-1:0] cnt_next;

  assign trigger    = !draining && (fifo_level != '0) && (fifo_level[1:0] == 2'b00)
                      && (chan_ctrl == 2'b01) && dma_global_en;
  assign host_ready = !draining && !trigger;
  assign hacc       = host_wr && host_ready;
  assign push       = hacc && (host_sel == SEL_DATA) && req_active && !fifo_full;

  assign mem_we    = draining && (xfer_count != '0);
  assign mem_addr  = dest_addr;
  assign mem_wdata = fifo_mem[rd_idx];

  assign len_next = mem_we ? host_len - DW'(host_len != '0) : host_len;
  assign cnt_next = mem_we ? xfer_count - CW'(1) : xfer_count;
  assign last     = draining && ((cnt_next == '0) || (LW'(rd_idx) + LW'(1) == drain_n));

  assign count_mismatch = (xfer_count != CW'(host_len));

  always_ff @(posedge clk) begin
    if (push) fifo_mem[fifo_level[IW-1:0]] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_len      <= '0;
      req_active    <= 1'b0;
      req_dma_en    <= 1'b0;
      req_rv        <= 1'b0;
      fifo_full     <= 1'b0;
      fifo_level    <= '0;
      dest_addr     <= '0;
      xfer_count    <= '0;
      chan_ctrl     <= 2'b00;
      dma_global_en <= 1'b0;
      draining      <= 1'b0;
      rd_idx        <= '0;
      drain_n       <= '0;
    end else begin
      if (hacc && host_sel == SEL_LEN)
        host_len <= {host_wdata[DW-1:2], 2'b00};
      else if (draining)
        host_len <= len_next;

      if (hacc && host_sel == SEL_CTRL) begin
        req_active <= host_wdata[2];
        req_dma_en <= host_wdata[1];
        req_rv     <= host_wdata[0];
      end else if (last && len_next == '0) begin
        req_active <= 1'b0;
      end

      if (push) begin
        fifo_level <= fifo_level + LW'(1);
        fifo_full  <= (fifo_level + LW'(1) == LW'(DEPTH));
      end

      if (trigger) begin
        draining <= 1'b1;
        rd_idx   <= '0;
        drain_n  <= fifo_level;
      end

      if (draining) begin
        xfer_count <= cnt_next;
        if (mem_we) begin
          dest_addr <= dest_addr + AW'(2);
          rd_idx    <= rd_idx + IW'(1);
        end
        if (last) begin
          draining   <= 1'b0;
          fifo_level <= '0;
          fifo_full  <= 1'b0;
          if (cnt_next == '0) chan_ctrl[1] <= 1'b1;
        end
      end else if (cfg_wr) begin
        case (cfg_sel)
          CFG_DEST: dest_addr     <= cfg_wdata;
          CFG_CNT:  xfer_count    <= cfg_wdata[CW-1:0];
          CFG_CHAN: chan_ctrl     <= cfg_wdata[1:0];
          CFG_GLB:  dma_global_en <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // R2
  len_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_ready && host_sel == SEL_LEN) |=> (host_len[1:0] == 2'b00));

  // R3
  data_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_ready && host_sel == SEL_DATA && !req_active) |=> (fifo_level == $past(fifo_level)));

  // R4
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(draining) |-> ($past(chan_ctrl) == 2'b01 && $past(dma_global_en)
                         && $past(fifo_level) != '0 && $past(fifo_level[1:0]) == 2'b00));

  // R5
  dest_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (dest_addr == $past(dest_addr) + AW'(2)));

  // R6
  end_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && xfer_count == CW'(1)) |=> chan_ctrl[1]);

  // R7
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (fifo_level == LW'(DEPTH)));

  // R9
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_ready && host_sel == SEL_CTRL) |=> (fifo_full == $past(fifo_full)));

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !host_ready);
endmodule

// File: tb/tb_dreq_fifo_bridge.sv
`timescale 1ns/1ps
module tb_dreq_fifo_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [15:0] host_wdata = '0;
  logic        host_ready;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] host_len;
  logic        req_active, req_dma_en, req_rv, fifo_full;
  logic [3:0]  fifo_level;
  logic [31:0] dest_addr;
  logic [23:0] xfer_count;
  logic [1:0]  chan_ctrl;
  logic        dma_global_en, mem_we, count_mismatch;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;

  dreq_fifo_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_ready(host_ready), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .host_len(host_len),
    .req_active(req_active), .req_dma_en(req_dma_en), .req_rv(req_rv),
    .fifo_full(fifo_full), .fifo_level(fifo_level), .dest_addr(dest_addr),
    .xfer_count(xfer_count), .chan_ctrl(chan_ctrl), .dma_global_en(dma_global_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .count_mismatch(count_mismatch)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int          cyc = 0;
  int          wn  = 0;
  int          overlap = 0;
  logic [31:0] la [32];
  logic [15:0] ld [32];
  int          lc [32];

  always @(negedge clk) begin
    if (rst_n) begin
      cyc <= cyc + 1;
      if (mem_we) begin
        if (wn < 32) begin
          la[wn] <= mem_addr;
          ld[wn] <= mem_wdata;
          lc[wn] <= cyc;
        end
        wn <= wn + 1;
        if (host_ready) overlap <= overlap + 1;
      end
    end
  end

  localparam logic [31:0] LEN_VEC [5] = '{
    {16'h0007, 16'h0004}, {16'hFFFF, 16'hFFFC}, {16'h0010, 16'h0010},
    {16'h0003, 16'h0000}, {16'h1235, 16'h1234}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] s, input logic [15:0] d, output bit waited);
    waited = 0;
    @(negedge clk);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    while (!host_ready) begin
      waited = 1;
      @(negedge clk);
    end
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic cwr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 len", host_len, 0);
    chk("R1 ctrl", {req_active, req_dma_en, req_rv}, 0);
    chk("R1 level/full", {fifo_level, fifo_full}, 0);
    chk("R1 dest", dest_addr, 0);
    chk("R1 count/chan/glb", {xfer_count, chan_ctrl, dma_global_en}, 0);
    chk("R1 we/ready", {mem_we, host_ready}, 2'b01);

    // R2 length alignment table
    for (int i = 0; i < 5; i++) begin
      hwr(2'd0, LEN_VEC[i][31:16], w);
      chk("R2 len", host_len, LEN_VEC[i][15:0]);
    end

    // R3 data ignored while inactive
    hwr(2'd1, 16'hAAAA, w);
    chk("R3 level", fifo_level, 0);

    cwr(2'd0, 32'h1000);
    cwr(2'd1, 32'd12);
    cwr(2'd2, 32'd1);
    hwr(2'd0, 16'd12, w);
    hwr(2'd2, 16'h0004, w);
    chk("R11 match", count_mismatch, 0);

    // R4 gated by global enable
    for (int i = 0; i < 4; i++) hwr(2'd1, 16'h1100 + 16'(i), w);
    idle(6);
    chk("R4 no drain level", fifo_level, 4);
    chk("R4 no writes", wn, 0);

    // R7 full
    for (int i = 4; i < 8; i++) hwr(2'd1, 16'h1100 + 16'(i), w);
    chk("R7 full", {fifo_full, fifo_level}, {1'b1, 4'd8});

    // R9 control write keeps full
    hwr(2'd2, 16'h0007, w);
    chk("R9 bits", {req_active, req_dma_en, req_rv}, 3'b111);
    chk("R9 full", fifo_full, 1);
    hwr(2'd2, 16'h0004, w);
    chk("R9 bits2", {req_active, req_dma_en, req_rv, fifo_full}, 4'b1001);

    // R5 eight word burst
    cwr(2'd3, 32'd1);
    idle(12);
    chk("R5 count of writes", wn, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R5 addr", la[i], 32'h1000 + 32'(2 * i));
      chk("R5 data", ld[i], 16'h1100 + 16'(i));
      if (i > 0) chk("R5 consecutive", lc[i] - lc[i-1], 1);
    end
    chk("R5 dest", dest_addr, 32'h1010);
    chk("R5 count", xfer_count, 4);
    chk("R5 len", host_len, 4);
    chk("R7 cleared", {fifo_level, fifo_full}, 0);
    chk("R6 not ended", chan_ctrl, 2'b01);
    chk("R8 still active", req_active, 1);

    // R11 mismatch, R10 stall
    hwr(2'd0, 16'd8, w);
    cwr(2'd1, 32'd6);
    chk("R11 mismatch", count_mismatch, 1);
    for (int i = 0; i < 4; i++) hwr(2'd1, 16'h2200 + 16'(i), w);
    hwr(2'd1, 16'h2204, w);
    chk("R10 stalled", w, 1);
    idle(10);
    chk("R10 burst writes", wn, 12);
    chk("R10 late word kept", fifo_level, 1);
    chk("R5 count after", xfer_count, 2);
    chk("R5 len after", host_len, 4);

    // R6 early stop
    for (int i = 5; i < 8; i++) hwr(2'd1, 16'h2200 + 16'(i), w);
    idle(10);
    chk("R6 writes", wn, 14);
    chk("R6 addr0", la[12], 32'h1018);
    chk("R6 data0", ld[12], 16'h2204);
    chk("R6 data1", ld[13], 16'h2205);
    chk("R6 count", xfer_count, 0);
    chk("R6 end bit", chan_ctrl, 2'b11);
    chk("R6 len", host_len, 2);
    chk("R7 cleared early", fifo_level, 0);

    // R4 ended channel does not drain
    for (int i = 0; i < 4; i++) hwr(2'd1, 16'h2300 + 16'(i), w);
    idle(6);
    chk("R4 ended no drain", wn, 14);

    // R8 length reaches zero
    cwr(2'd1, 32'd4);
    hwr(2'd0, 16'd4, w);
    chk("R11 match again", count_mismatch, 0);
    cwr(2'd2, 32'd1);
    idle(10);
    chk("R8 writes", wn, 18);
    chk("R8 data", ld[17], 16'h2303);
    chk("R8 len", host_len, 0);
    chk("R8 active cleared", req_active, 0);
    chk("R6 end again", chan_ctrl, 2'b11);
    hwr(2'd1, 16'h5555, w);
    chk("R3 ignored after", fifo_level, 0);

    chk("R10 no ready during write", overlap, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule